// File: doc/BRIEF.md
# Supply-Aware Startup Sequencer

This block steps a sensor's digital core through power-up and brown-out. Two comparator outputs arrive from the analog side: one says the supply is above the power-on-reset level, the other says it is above the undervoltage level. Each comparator already has analog hysteresis. The sequencer holds the core in reset while the supply is too low. Once the supply clears the power-on-reset level it asks a copy engine to move the nonvolatile settings into RAM. It then waits a programmable number of clock cycles and starts the main processing program. It drives the output stage only while the supply is above the undervoltage level.

Both comparator inputs pass through a two-flop synchronizer before the state machine uses them. When the power-on-reset comparator drops, the sequencer goes straight back to reset from any state, and any copy in progress is abandoned. A dip below the undervoltage level that stays above the power-on-reset level puts the output in high impedance and leaves the program running. When the supply recovers from such a dip, the output comes back with no reload and no startup wait.

Top module: `supply_seq`

## Requirements
- R1: While rst_ni is low and afterwards with por_ok_i low, core_rst_o is 1 and load_start_o, out_en_o and run_en_o are 0.
- R2: Each comparator input passes through two synchronizing flops. A change at the input shows at the outputs after the third rising clock edge, and not after the second.
- R3: After por_ok_i rises, the block leaves reset. From then until load_done_i is sampled high, core_rst_o is 0 and load_start_o is 1. load_start_o falls on the edge that samples load_done_i high.
- R4: Let N be the value of startup_cycles_i on the edge that samples load_done_i high in the load phase. With uv_ok_i high, out_en_o and run_en_o rise N+1 clock edges after that edge.
- R5: While running, if uv_ok_i falls (por_ok_i still high), out_en_o falls after the third edge. run_en_o stays 1 and core_rst_o stays 0.
- R6: When uv_ok_i rises again from the undervoltage state, out_en_o returns after the third edge. load_start_o stays 0 and no startup wait is applied.
- R7: If por_ok_i falls in any state, core_rst_o is 1 after the third edge, with load_start_o, out_en_o and run_en_o at 0. A load that is in progress is abandoned, and the next rise of por_ok_i performs a full reload.
- R8: If uv_ok_i is low when the startup wait ends, the block enters the undervoltage state: run_en_o is 1 and out_en_o is 0. The output is enabled only once uv_ok_i is high.
- R9: load_done_i has no effect outside the load phase. When it is pulsed while running, out_en_o stays 1 and load_start_o stays 0.
- R10: Changes to startup_cycles_i after the load is accepted do not alter the wait that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_ok_i | input | 1 | Supply above power-on-reset level (asynchronous) |
| uv_ok_i | input | 1 | Supply above undervoltage level (asynchronous) |
| load_done_i | input | 1 | Copy engine reports settings loaded |
| startup_cycles_i | input | DLY_W | Startup wait length in cycles |
| core_rst_o | output | 1 | Internal reset for the digital core |
| load_start_o | output | 1 | Request to copy nonvolatile settings to RAM |
| out_en_o | output | 1 | Output drive enable (0 = high impedance) |
| run_en_o | output | 1 | Main program enable |

## Verification
The assertions check the following on every cycle:
- each synchronizer stage follows the one before it by one edge;
- a synchronized power-on-reset low always leads to reset on the next edge;
- a synchronized undervoltage low never lets the output be enabled on the next edge;
- the load and wait states hold until their exit conditions arrive;
- the timer counts down by exactly one.

The bench scenarios sweep the startup length and show the things the assertions do not:
- the exact three-edge latency through the synchronizers;
- the N+1 edge spacing from load acceptance to output enable;
- recovery from undervoltage without a reload;
- a full reload after a load is abandoned;
- that a late load_done_i or a changed startup length is ignored.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_LOAD  = 3'd1,
    ST_DELAY = 3'd2,
    ST_RUN   = 3'd3,
    ST_UV    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/supply_seq_sync.sv
module supply_seq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end

    p_stage_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (stg_q[s] == $past(stg_q[s-1])));
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/supply_seq_timer.sv
module supply_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R10: once loaded, the count only moves down by one.
  p_count_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_count_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
  import supply_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_s_i,
  input  logic uv_s_i,
  input  logic load_done_i,
  input  logic tmr_zero_i,
  output logic tmr_load_o,
  output logic core_rst_o,
  output logic load_start_o,
  output logic out_en_o,
  output logic run_en_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    if (!por_s_i) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET: state_d = ST_LOAD;
        ST_LOAD: if (load_done_i) begin
          state_d    = ST_DELAY;
          tmr_load_o = 1'b1;
        end
        ST_DELAY: if (tmr_zero_i) state_d = uv_s_i ? ST_RUN : ST_UV;
        ST_RUN:   if (!uv_s_i)    state_d = ST_UV;
        ST_UV:    if (uv_s_i)     state_d = ST_RUN;
        default:  state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  always_comb begin
    core_rst_o   = (state_q == ST_RESET);
    load_start_o = (state_q == ST_LOAD);
    out_en_o     = (state_q == ST_RUN);
    run_en_o     = (state_q == ST_RUN) || (state_q == ST_UV);
  end

  p_por_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_s_i |=> (state_q == ST_RESET));

  p_uv_blocks_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_s_i |=> !out_en_o);

  p_uv_recover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UV && por_s_i && uv_s_i) |=> (state_q == ST_RUN));

  p_load_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && por_s_i && !load_done_i) |=> (state_q == ST_LOAD));

  p_delay_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY && por_s_i && !tmr_zero_i) |=> (state_q == ST_DELAY));

  p_delay_uv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY && por_s_i && tmr_zero_i && !uv_s_i) |=> (state_q == ST_UV));
endmodule

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ok_i,
  input  logic             uv_ok_i,
  input  logic             load_done_i,
  input  logic [DLY_W-1:0] startup_cycles_i,
  output logic             core_rst_o,
  output logic             load_start_o,
  output logic             out_en_o,
  output logic             run_en_o
);
  localparam int NCMP = 2;

  logic [NCMP-1:0] cmp_s;
  logic            tmr_load, tmr_zero;

  supply_seq_sync #(.WIDTH(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({uv_ok_i, por_ok_i}),
    .q_o   (cmp_s)
  );

  supply_seq_timer #(.W(DLY_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (startup_cycles_i),
    .zero_o(tmr_zero)
  );

  supply_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_s_i     (cmp_s[0]),
    .uv_s_i      (cmp_s[1]),
    .load_done_i (load_done_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .core_rst_o  (core_rst_o),
    .load_start_o(load_start_o),
    .out_en_o    (out_en_o),
    .run_en_o    (run_en_o)
  );
endmodule

// File: tb/tb_supply_seq.sv
`timescale 1ns/1ps
module tb_supply_seq;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, por_ok, uv_ok, load_done;
  logic [DLY_W-1:0] startup;
  logic             core_rst, load_start, out_en, run_en;
  int errs = 0, checks = 0;

  supply_seq #(.DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por_ok), .uv_ok_i(uv_ok),
    .load_done_i(load_done), .startup_cycles_i(startup),
    .core_rst_o(core_rst), .load_start_o(load_start),
    .out_en_o(out_en), .run_en_o(run_en)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input int n);
    startup = DLY_W'(n); por_ok = 1'b1; uv_ok = 1'b1;
    tick(2);
    chk("R2", "core_rst before 3rd edge", core_rst, 1'b1);
    chk("R2", "load_start before 3rd edge", load_start, 1'b0);
    tick(1);
    chk("R3", "load_start", load_start, 1'b1);
    chk("R3", "core_rst", core_rst, 1'b0);
    tick(3);
    chk("R3", "load_start held", load_start, 1'b1);
    chk("R3", "out_en in load", out_en, 1'b0);
    load_done = 1'b1;
    tick(1);
    load_done = 1'b0;
    startup = ~DLY_W'(n);  // R10: late change must not matter
    chk("R3", "load_start after done", load_start, 1'b0);
    tick(n);
    chk("R4", "out_en before N+1", out_en, 1'b0);
    chk("R10", "run_en before N+1", run_en, 1'b0);
    tick(1);
    chk("R4", "out_en at N+1", out_en, 1'b1);
    chk("R4", "run_en at N+1", run_en, 1'b1);
  endtask

  task automatic uv_dip();
    uv_ok = 1'b0;
    tick(2);
    chk("R5", "out_en before 3rd edge", out_en, 1'b1);
    tick(1);
    chk("R5", "out_en low", out_en, 1'b0);
    chk("R5", "run_en kept", run_en, 1'b1);
    chk("R5", "core_rst low", core_rst, 1'b0);
    tick(4);
    uv_ok = 1'b1;
    tick(2);
    chk("R6", "out_en still low", out_en, 1'b0);
    tick(1);
    chk("R6", "out_en back", out_en, 1'b1);
    chk("R6", "no reload", load_start, 1'b0);
  endtask

  task automatic por_drop();
    por_ok = 1'b0;
    tick(2);
    chk("R7", "core_rst before 3rd edge", core_rst, 1'b0);
    tick(1);
    chk("R7", "core_rst", core_rst, 1'b1);
    chk("R7", "out_en", out_en, 1'b0);
    chk("R7", "run_en", run_en, 1'b0);
    chk("R7", "load_start", load_start, 1'b0);
    uv_ok = 1'b0;
    tick(2);
  endtask

  initial begin
    rst_n = 1'b0; por_ok = 1'b0; uv_ok = 1'b0; load_done = 1'b0; startup = '0;
    tick(3);
    chk("R1", "core_rst in reset", core_rst, 1'b1);
    chk("R1", "out_en in reset", out_en, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1", "core_rst por low", core_rst, 1'b1);
    chk("R1", "load_start por low", load_start, 1'b0);
    chk("R1", "run_en por low", run_en, 1'b0);

    for (int n = 0; n < 10; n++) begin
      power_up(n);
      // R9: stray done while running
      load_done = 1'b1;
      tick(1);
      load_done = 1'b0;
      tick(2);
      chk("R9", "load_start stays low", load_start, 1'b0);
      chk("R9", "out_en stays high", out_en, 1'b1);
      uv_dip();
      if (n % 2 == 1) begin
        uv_ok = 1'b0;
        tick(3);
        chk("R5", "in uv before por drop", out_en, 1'b0);
      end
      por_drop();
    end

    // R7: abort a load, then full reload
    por_ok = 1'b1; uv_ok = 1'b1;
    tick(3);
    chk("R7", "load started", load_start, 1'b1);
    por_ok = 1'b0;
    tick(3);
    chk("R7", "load aborted", load_start, 1'b0);
    chk("R7", "back in reset", core_rst, 1'b1);
    power_up(5);
    por_drop();

    // R8: undervoltage during startup wait
    startup = 8'd12; por_ok = 1'b1; uv_ok = 1'b1;
    tick(3);
    load_done = 1'b1;
    tick(1);
    load_done = 1'b0;
    uv_ok = 1'b0;
    tick(13);
    chk("R8", "out_en after wait in uv", out_en, 1'b0);
    chk("R8", "run_en after wait in uv", run_en, 1'b1);
    uv_ok = 1'b1;
    tick(3);
    chk("R8", "out_en after uv ok", out_en, 1'b1);
    chk("R8", "no reload", load_start, 1'b0);
    por_drop();

    // R4: longer wait
    power_up(40);
    por_drop();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500000;
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule